// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received Ethernet frames into memory. Software keeps a ring of descriptors. Each descriptor is two 32-bit words: a status word at offset 0 and a buffer address at offset 4. Software writes the ring base pointer and sets the receive-enable bit. When a frame starts, the engine reads the current descriptor's status word. It goes on only if the descriptor's owner bit shows that hardware holds it. In that case it reads the buffer address and stores the frame bytes as big-endian 32-bit words. It then writes back a status word that holds the stored length, the error flags and a cleared owner bit.

After the write-back, the descriptor pointer moves to the next descriptor. If the descriptor's wrap bit is set, the pointer returns to the ring base instead. The pointer always stays inside the 1 KiB window that holds the base. Sometimes the fetched descriptor has not been handed back by software. In that case the engine clears receive-enable and throws the frame away. Every later frame is also thrown away until software sets receive-enable again.

The frame input is a byte stream with a valid/ready handshake and a last-byte marker. The three error flags are sampled together with the last byte. The memory port accepts one word access per cycle, and read data returns on the cycle after the request.

Top module: `rx_ring_dma`

## Requirements
- R1: After a frame starts, the engine reads the status word at the descriptor pointer. If bit 11 (owner) is clear, it clears receive-enable and consumes the frame to its last byte. It writes nothing, and the descriptor pointer does not change.
- R2: Frame bytes go to consecutive words starting at the buffer address, with its two low bits forced to zero. Byte 4k+j of the frame lands in bits [31-8j:24-8j] of word k. Unused lanes of the final word are written as zero.
- R3: The status write-back holds the stored length in bits [10:0] and clears owner bit 11. It keeps wrap bit 12 as fetched. It sets bit 13 for too-long, bit 14 for alignment error, bit 15 for overrun and bit 16 for CRC error, with the last three taken from the flags given with the last byte. All other bits are zero.
- R4: At most 1540 bytes are stored. A longer frame reports length 1540 and sets the too-long flag, and nothing is written past the 1540th byte.
- R5: After the write-back, the descriptor pointer goes to the ring base if the wrap bit was set. Otherwise it moves forward by 8 bytes.
- R6: Moving forward keeps the upper address bits of the ring base, so the pointer wraps from the window's last descriptor back to offset 0 of the 1 KiB window.
- R7: A base write while no frame is in progress loads the base with the low 10 bits cleared, and it also loads the descriptor pointer with the same value.
- R8: While receive-enable is 0, the input is always ready and frames are discarded with no memory access. A pulse on `rx_en_set` turns reception back on.
- R9: After reset, receive-enable is 0, the descriptor pointer is 0 and no memory request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Load the ring base register |
| base_wdata | input | 32 | New ring base (low 10 bits ignored) |
| rx_en_set | input | 1 | Set receive-enable |
| rx_en | output | 1 | Receive-enable state |
| desc_ptr | output | 32 | Address of the current descriptor |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_err_align | input | 1 | Alignment error, sampled with the last byte |
| in_err_overrun | input | 1 | Overrun error, sampled with the last byte |
| in_err_crc | input | 1 | CRC error, sampled with the last byte |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word address in bytes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the request |

## Verification
Frames of 64, 5 and 1 bytes test full words against zero-filled partial words. Each one carries a different mix of error flags, which shows that every flag lands in its own bit. A 1600-byte frame on the wrap descriptor tests truncation, the too-long flag and the return to the base in one pass. A descriptor that was not handed back, and then a frame sent with reception off, separate the drop path from normal storing. Ending the walk through 128 descriptors without a wrap bit tests that the pointer stays inside its 1 KiB window. Every memory write is compared on its own clock against a queue of expected writes, so a stray or reordered write shows up at once.

// File: rtl/rx_ring_dma.sv
module rx_ring_dma #(
  parameter int AW        = 32,
  parameter int BUF_BYTES = 1540,
  parameter int LEN_W     = 11,
  parameter int RING_BITS = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_we,
  input  logic [AW-1:0] base_wdata,
  input  logic          rx_en_set,
  output logic          rx_en,
  output logic [AW-1:0] desc_ptr,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic          in_err_align,
  input  logic          in_err_overrun,
  input  logic          in_err_crc,
  output logic          in_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);
  localparam int OWN_B  = LEN_W;
  localparam int WRAP_B = LEN_W + 1;
  localparam int LONG_B = LEN_W + 2;
  localparam int ALN_B  = LEN_W + 3;
  localparam int OVR_B  = LEN_W + 4;
  localparam int CRC_B  = LEN_W + 5;
  localparam logic [RING_BITS-1:0] DESC_STEP = RING_BITS'(8);
  localparam logic [LEN_W-1:0]     BUF_LIM   = LEN_W'(BUF_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_STAT, S_ADDR, S_DATA, S_WB, S_DROP} st_t;

  st_t             state;
  logic [AW-1:0]   base, buf_q;
  logic [LEN_W-1:0] cnt;
  logic [31:0]     pw;
  logic            wrap_q, too_long;
  logic [2:0]      flags;

  logic            take, room, data_wr;
  logic [1:0]      lane;
  logic [31:0]     word_now, status_wb;
  logic [AW-1:0]   next_ptr, win_mask;

  assign win_mask = {{(AW-RING_BITS){1'b1}}, {RING_BITS{1'b0}}};
  assign in_ready = (state == S_DATA) || (state == S_DROP) || (state == S_IDLE && !rx_en);
  assign take     = in_valid && in_ready;
  assign room     = cnt < BUF_LIM;
  assign lane     = cnt[1:0];
  assign word_now = pw | (32'(in_data) << {~lane, 3'b000});
  assign data_wr  = (state == S_DATA) && take && room && (lane == 2'd3 || in_last);
  assign next_ptr = wrap_q ? base : {desc_ptr[AW-1:RING_BITS], desc_ptr[RING_BITS-1:0] + DESC_STEP};

  always_comb begin
    status_wb = '0;
    status_wb[LEN_W-1:0] = cnt;
    status_wb[WRAP_B] = wrap_q;
    status_wb[LONG_B] = too_long;
    status_wb[ALN_B]  = flags[0];
    status_wb[OVR_B]  = flags[1];
    status_wb[CRC_B]  = flags[2];
  end

  always_comb begin
    mem_req = 1'b0;
    mem_we = 1'b0;
    mem_addr = desc_ptr;
    mem_wdata = status_wb;
    case (state)
      S_IDLE: mem_req = rx_en && in_valid;
      S_STAT: begin
        mem_req = mem_rdata[OWN_B];
        mem_addr = desc_ptr + AW'(4);
      end
      S_DATA: begin
        mem_req = data_wr;
        mem_we = data_wr;
        mem_addr = buf_q + AW'({cnt[LEN_W-1:2], 2'b00});
        mem_wdata = word_now;
      end
      S_WB: begin
        mem_req = 1'b1;
        mem_we = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      base <= '0;
      desc_ptr <= '0;
      rx_en <= 1'b0;
      buf_q <= '0;
      cnt <= '0;
      pw <= '0;
      wrap_q <= 1'b0;
      too_long <= 1'b0;
      flags <= '0;
    end else begin
      if (rx_en_set) rx_en <= 1'b1;
      case (state)
        S_IDLE: begin
          if (base_we) begin
            base <= base_wdata & win_mask;
            desc_ptr <= base_wdata & win_mask;
          end
          if (!rx_en) begin
            if (take && !in_last) state <= S_DROP;
          end else if (in_valid) state <= S_STAT;
        end
        S_STAT: begin
          if (!mem_rdata[OWN_B]) begin
            rx_en <= 1'b0;
            state <= S_DROP;
          end else begin
            wrap_q <= mem_rdata[WRAP_B];
            state <= S_ADDR;
          end
        end
        S_ADDR: begin
          buf_q <= mem_rdata & {{(AW-2){1'b1}}, 2'b00};
          cnt <= '0;
          pw <= '0;
          too_long <= 1'b0;
          state <= S_DATA;
        end
        S_DATA: begin
          if (take) begin
            if (room) begin
              cnt <= cnt + 1'b1;
              pw <= (lane == 2'd3) ? 32'd0 : word_now;
            end else too_long <= 1'b1;
            if (in_last) begin
              flags <= {in_err_crc, in_err_overrun, in_err_align};
              state <= S_WB;
            end
          end
        end
        S_WB: begin
          desc_ptr <= next_ptr;
          state <= S_IDLE;
        end
        S_DROP: if (take && in_last) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r3_wb_releases: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_WB |-> mem_we && !mem_wdata[OWN_B] && mem_addr == desc_ptr);
  a_r4_inside_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA && mem_we) |-> (mem_addr - buf_q) < AW'(BUF_BYTES));
  a_r1_enable_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_en) |-> $past(state) == S_STAT && !$past(mem_rdata[OWN_B]));
  a_r6_window: assert property (@(posedge clk) disable iff (!rst_n)
    desc_ptr[AW-1:RING_BITS] == base[AW-1:RING_BITS]);
  a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !rx_en) |-> !mem_req);
endmodule

// File: tb/rx_ring_dma_bench.sv
module rx_ring_dma_bench;
  logic clk = 0, rst_n = 0;
  logic base_we = 0, rx_en_set = 0;
  logic [31:0] base_wdata = 0;
  logic rx_en, in_ready, mem_req, mem_we;
  logic [31:0] desc_ptr, mem_addr, mem_wdata, mem_rdata;
  logic in_valid = 0, in_last = 0, e_aln = 0, e_ovr = 0, e_crc = 0;
  logic [7:0] in_data = 0;

  always #4 clk = ~clk;

  rx_ring_dma u_rx_ring_dma (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .rx_en_set(rx_en_set), .rx_en(rx_en), .desc_ptr(desc_ptr),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_err_align(e_aln), .in_err_overrun(e_ovr), .in_err_crc(e_crc),
    .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  int tests = 0, fails = 0;
  bit done = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] exp_a [$];
  logic [31:0] exp_d [$];
  logic [31:0] m_base = 0, m_ptr = 0;
  bit m_en = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (mem_req && mem_we) begin
      tests++;
      if (exp_a.size() == 0) begin
        fails++;
        $display("FAIL R1/R8 stray write actual=%h:%h expected=none", mem_addr, mem_wdata);
      end else begin
        logic [31:0] ea, ed;
        ea = exp_a.pop_front();
        ed = exp_d.pop_front();
        if (mem_addr !== ea || mem_wdata !== ed) begin
          fails++;
          $display("FAIL R2/R3/R4 write actual=%h:%h expected=%h:%h", mem_addr, mem_wdata, ea, ed);
        end
      end
      mem[mem_addr] = mem_wdata;
    end else if (mem_req) mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'd0;
  end

  function automatic logic [7:0] bval(int i, int seed);
    return 8'((i * 7 + seed) & 255);
  endfunction

  task automatic model(int n, int seed, bit a, bit o, bit c);
    logic [31:0] st, bufa, w, s;
    int len;
    if (!m_en) return;
    st = mem.exists(m_ptr) ? mem[m_ptr] : 32'd0;
    if (!st[11]) begin m_en = 0; return; end
    bufa = mem[m_ptr + 4] & ~32'd3;
    len = n > 1540 ? 1540 : n;
    for (int k = 0; k < (len + 3) / 4; k++) begin
      w = 0;
      for (int j = 0; j < 4; j++)
        if (4 * k + j < len) w |= 32'(bval(4 * k + j, seed)) << (24 - 8 * j);
      exp_a.push_back(bufa + 32'(4 * k));
      exp_d.push_back(w);
    end
    s = 32'(len) | (32'(st[12]) << 12) | (32'(n > 1540) << 13) | (32'(a) << 14) | (32'(o) << 15) | (32'(c) << 16);
    exp_a.push_back(m_ptr);
    exp_d.push_back(s);
    m_ptr = st[12] ? m_base : {m_base[31:10], m_ptr[9:0] + 10'd8};
  endtask

  task automatic frame(string req, int n, int seed, bit a, bit o, bit c);
    model(n, seed, a, o, c);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = bval(i, seed); in_last = (i == n - 1);
      e_aln = in_last & a; e_ovr = in_last & o; e_crc = in_last & c;
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_last = 0; e_aln = 0; e_ovr = 0; e_crc = 0;
    repeat (4) @(negedge clk);
    chk({req, " queue"}, 32'(exp_a.size()), 0);
    chk({req, " ptr"}, desc_ptr, m_ptr);
    chk({req, " en"}, 32'(rx_en), 32'(m_en));
  endtask

  task automatic set_base(logic [31:0] v);
    @(negedge clk); base_we = 1; base_wdata = v;
    @(negedge clk); base_we = 0;
    m_base = v & 32'hFFFF_FC00; m_ptr = m_base;
  endtask

  task automatic enable();
    @(negedge clk); rx_en_set = 1;
    @(negedge clk); rx_en_set = 0;
    m_en = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 rx_en", 32'(rx_en), 0);
    chk("R9 mem_req", 32'(mem_req), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R9 ptr", desc_ptr, 0);
    chk("R9 ready when off", 32'(in_ready), 1);
    set_base(32'h1234_5678);
    chk("R7 base mask", desc_ptr, 32'h1234_5400);
    set_base(32'h0000_0400);
    for (int i = 0; i < 4; i++) begin
      mem[32'h400 + 8 * i] = (i == 3) ? 32'h1800 : 32'h0800;
      mem[32'h404 + 8 * i] = 32'h1000 + 32'h800 * i + (i == 1 ? 2 : 0);
    end
    enable();
    chk("R8 enable", 32'(rx_en), 1);
    frame("R2 R3 R5 64B", 64, 1, 0, 0, 0);
    frame("R2 R3 5B crc", 5, 9, 0, 0, 1);
    frame("R2 R3 1B aln ovr", 1, 3, 1, 1, 0);
    frame("R4 R5 long wrap", 1600, 5, 0, 0, 0);
    chk("R5 back to base", desc_ptr, 32'h400);
    frame("R1 not owned", 12, 2, 0, 0, 1);
    chk("R1 dropped en", 32'(rx_en), 0);
    chk("R1 status untouched", mem[32'h400], 32'h0000_0040);
    frame("R8 off drop", 7, 4, 0, 0, 0);
    mem[32'h400] = 32'h0800;
    enable();
    frame("R1 R8 resumed", 4, 6, 1, 0, 0);
    chk("R1 resumed status", mem[32'h400], 32'h0000_4004);
    set_base(32'h0000_0800);
    for (int i = 0; i < 128; i++) begin
      mem[32'h800 + 8 * i] = 32'h0800;
      mem[32'h804 + 8 * i] = 32'h10000 + 16 * i;
    end
    for (int i = 0; i < 127; i++) frame("R6 walk", 1, i, 0, 0, 0);
    chk("R6 last slot", desc_ptr, 32'h0BF8);
    frame("R6 window wrap", 1, 200, 0, 0, 0);
    chk("R6 wrapped", desc_ptr, 32'h0800);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule